// File: doc/BRIEF.md
# Drive LED Serializer

This block keeps three indicator bits per drive port (activity, locate, fault) in a pattern register and sends the whole pattern to an external LED controller over three wires: a serial clock, a load strobe and a data line. A request names a port and carries a 32-bit state word. The block decodes the state word into the port's three bits and places them at the LED slot that a writable port-to-slot table gives for that port. It then sends one complete frame.

A frame starts with a configurable number of idle clocks. One clock follows with the load strobe high. Next come three data bits for every port, lowest pattern bit first. A configurable number of trailing clocks ends the frame. Each serial clock is a high phase followed by a low phase, and each phase lasts `HALF_TICKS` system cycles. The leading and trailing clock counts are sampled from `pre_clocks` and `post_clocks` when a request is accepted. Tying both inputs to zero gives frames with no idle or trailing clocks.

Top module: `led_shift_serializer`

## Requirements
- R1: After reset `sclk`, `sload`, `sdata` and `busy` are low, every pattern bit is zero, and port p maps to slot p.
- R2: On an accepted request the port's activity bit is set when state bit 20 or state bit 21 is 1. Locate follows state bit 19 and fault follows state bit 22. Each of the three is cleared when its source bits are 0.
- R3: The three bits for port p sit at pattern positions 3*s (activity), 3*s+1 (locate) and 3*s+2 (fault), where s is the slot that the table holds for p. A pulse on `map_we` stores `map_slot` as the slot of `map_port`.
- R4: A request whose slot field, state bits [15:8], is at or above `SLOT_LIMIT` (15) is rejected. The pattern is left unchanged and no frame is sent.
- R5: A request that arrives while `busy` is high is ignored and leaves the pattern unchanged.
- R6: A frame holds, in order: `pre_clocks` idle clocks, one load clock, 3*`NPORTS` data clocks carrying pattern bits 0 upward, then `post_clocks` trailing clocks. `sdata` is 0 on every clock that is not a data clock.
- R7: Every serial clock is high for exactly `HALF_TICKS` cycles and then low for exactly `HALF_TICKS` cycles.
- R8: `busy` rises in the cycle after the accepting edge, starts high together with the first `sclk` high phase, and stays high for exactly (pre+1+3*NPORTS+post)*2*HALF_TICKS cycles.
- R9: `sdata` never changes while `sclk` is high, and it holds its value across each rising edge of `sclk`.
- R10: `sload` is high for the load clock only. It rises together with `sclk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Update request strobe |
| req_port | input | PW | Port being updated |
| req_state | input | 32 | State word: LED sources and slot field |
| map_we | input | 1 | Slot table write strobe |
| map_port | input | PW | Table entry to write |
| map_slot | input | PW | Slot value to store |
| pre_clocks | input | CFG_W | Idle clocks before load |
| post_clocks | input | CFG_W | Trailing clocks after data |
| sclk | output | 1 | Serial clock to LED controller |
| sload | output | 1 | Load strobe |
| sdata | output | 1 | Serial data |
| busy | output | 1 | Frame in progress |

## Verification
A request is sampled at one rising edge, and `busy` together with the first `sclk` high phase is due one cycle later. The bench therefore drives each request for one cycle and starts sampling at the next falling edge. From there it samples every falling edge until `busy` drops. It records `sload` and `sdata` at each low-to-high step of `sclk` and measures the length of every high and low run, so clock counts, bit order and phase lengths are all checked against the bench's own pattern model. For rejected requests and requests made while a frame runs, the bench watches `busy` for several cycles. The following frame then shows whether the pattern stayed unchanged.

// File: rtl/led_shift_serializer.sv
module led_shift_serializer #(
  parameter int NPORTS     = 8,
  parameter int HALF_TICKS = 4,
  parameter int SLOT_LIMIT = 15,
  parameter int CFG_W      = 8,
  localparam int PW        = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [PW-1:0]    req_port,
  input  logic [31:0]      req_state,
  input  logic             map_we,
  input  logic [PW-1:0]    map_port,
  input  logic [PW-1:0]    map_slot,
  input  logic [CFG_W-1:0] pre_clocks,
  input  logic [CFG_W-1:0] post_clocks,
  output logic             sclk,
  output logic             sload,
  output logic             sdata,
  output logic             busy
);
  localparam int NBITS = 3 * NPORTS;
  localparam int HW    = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam int CW    = $clog2(NBITS) + CFG_W;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_LOAD, S_DATA, S_POST} st_t;

  st_t              st;
  logic [PW-1:0]    slot_map [NPORTS];
  logic [NBITS-1:0] pattern, shreg, nxt_pat;
  logic [HW-1:0]    tick;
  logic             ph;
  logic [CW-1:0]    cnt;
  logic [CFG_W-1:0] pre_q, post_q;
  logic             unused_bits;

  assign unused_bits = ^{req_state[31:23], req_state[7:0]};

  wire accept   = req_valid && (st == S_IDLE) && (int'(req_state[15:8]) < SLOT_LIMIT);
  wire half_end = (tick == HW'(HALF_TICKS - 1));
  wire clk_end  = half_end && !ph;

  always_comb begin
    int base;
    nxt_pat = pattern;
    base = 3 * int'(slot_map[req_port]);
    nxt_pat[base]     = req_state[20] | req_state[21];
    nxt_pat[base + 1] = req_state[19];
    nxt_pat[base + 2] = req_state[22];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPORTS; i++) slot_map[i] <= PW'(i);
    end else if (map_we) begin
      slot_map[map_port] <= map_slot;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ph      <= 1'b0;
      tick    <= '0;
      cnt     <= '0;
      pattern <= '0;
      shreg   <= '0;
      pre_q   <= '0;
      post_q  <= '0;
    end else if (st == S_IDLE) begin
      if (accept) begin
        pattern <= nxt_pat;
        shreg   <= nxt_pat;
        pre_q   <= pre_clocks;
        post_q  <= post_clocks;
        st      <= (pre_clocks != '0) ? S_PRE : S_LOAD;
        ph      <= 1'b1;
        tick    <= '0;
        cnt     <= '0;
      end
    end else begin
      tick <= half_end ? '0 : tick + HW'(1);
      if (half_end) ph <= ~ph;
      if (half_end && ph && st == S_DATA) shreg <= shreg >> 1;
      if (clk_end) begin
        case (st)
          S_PRE:
            if (cnt == CW'(pre_q) - CW'(1)) begin st <= S_LOAD; cnt <= '0; end
            else cnt <= cnt + CW'(1);
          S_LOAD: begin st <= S_DATA; cnt <= '0; end
          S_DATA:
            if (cnt == CW'(NBITS - 1)) begin
              st  <= (post_q != '0) ? S_POST : S_IDLE;
              cnt <= '0;
            end else cnt <= cnt + CW'(1);
          S_POST:
            if (cnt == CW'(post_q) - CW'(1)) begin st <= S_IDLE; cnt <= '0; end
            else cnt <= cnt + CW'(1);
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign busy  = (st != S_IDLE);
  assign sclk  = busy && ph;
  assign sload = (st == S_LOAD);
  assign sdata = ((st == S_DATA) || (st == S_LOAD && !ph)) ? shreg[0] : 1'b0;

  // R9
  sdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(sdata));

  // R5
  pattern_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(pattern));

  // R4
  slot_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy && (int'(req_state[15:8]) >= SLOT_LIMIT) |=> !busy);

  // R10
  load_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sload) |-> $rose(sclk));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> sclk);

  // R7
  high_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |=> sclk);
endmodule

// File: tb/sim_led_shift_serializer.sv
module sim_led_shift_serializer;
  localparam int NP = 8, H = 4, LIM = 15, NB = 3 * NP;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, map_we = 0;
  logic [2:0] req_port = 0, map_port = 0, map_slot = 0;
  logic [31:0] req_state = 0;
  logic [7:0] pre_clocks = 0, post_clocks = 0;
  logic sclk, sload, sdata, busy;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [NB-1:0] exp_pat = '0;
  logic [2:0] exp_map [NP];

  always #5 clk = ~clk;

  led_shift_serializer #(.NPORTS(NP), .HALF_TICKS(H), .SLOT_LIMIT(LIM), .CFG_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(req_port),
    .req_state(req_state), .map_we(map_we), .map_port(map_port), .map_slot(map_slot),
    .pre_clocks(pre_clocks), .post_clocks(post_clocks),
    .sclk(sclk), .sload(sload), .sdata(sdata), .busy(busy));

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [NB-1:0] upd(input logic [NB-1:0] pat, input int p, input logic [31:0] st);
    int b = 3 * int'(exp_map[p]);
    pat[b]     = st[20] | st[21];
    pat[b + 1] = st[19];
    pat[b + 2] = st[22];
    return pat;
  endfunction

  task automatic remap(input int p, input int s);
    @(negedge clk);
    map_we = 1; map_port = 3'(p); map_slot = 3'(s);
    @(negedge clk);
    map_we = 0;
    exp_map[p] = 3'(s);
  endtask

  task automatic frame(input int p, input logic [31:0] st, input int pre, input int post, input bit poke);
    bit acc = int'(st[15:8]) < LIM;
    int cyc = 0, nrise = 0, run = 0, bad_ph = 0, bad_bits = 0, bad_ld = 0, bad_hold = 0;
    int expn = pre + 1 + NB + post;
    bit prev = 0, prev_d = 0;
    @(negedge clk);
    req_valid = 1; req_port = 3'(p); req_state = st;
    pre_clocks = 8'(pre); post_clocks = 8'(post);
    @(negedge clk);
    req_valid = 0;
    if (!acc) begin
      bit any = 0;
      repeat (6) begin if (busy) any = 1; @(negedge clk); end
      chk(!any, "R4 rejected slot sent a frame", any, 0);
      return;
    end
    exp_pat = upd(exp_pat, p, st);
    while (busy) begin
      cyc++;
      if (sclk && !prev) begin
        bit el = (nrise == pre);
        bit ed = (nrise > pre && nrise <= pre + NB) ? exp_pat[nrise - pre - 1] : 1'b0;
        if (sload !== el) bad_ld++;
        if (sdata !== ed) bad_bits++;
        nrise++;
      end
      if (sclk && prev && sdata !== prev_d) bad_hold++;
      if (sclk != prev && cyc > 1) begin
        if (run != H) bad_ph++;
        run = 0;
      end
      run++;
      prev = sclk; prev_d = sdata;
      if (poke && cyc == 5) begin
        req_valid = 1; req_port = 0; req_state = 32'h0078_0000;
      end
      if (poke && cyc == 6) req_valid = 0;
      @(negedge clk);
    end
    if (run != H) bad_ph++;
    chk(nrise == expn, "R6 serial clock count", nrise, expn);
    chk(bad_bits == 0, "R2 R3 R6 data bits", bad_bits, 0);
    chk(bad_ld == 0, "R10 load strobe placement", bad_ld, 0);
    chk(bad_ph == 0, "R7 phase length", bad_ph, 0);
    chk(cyc == expn * 2 * H, "R8 busy length", cyc, expn * 2 * H);
    chk(bad_hold == 0, "R9 data stable while clock high", bad_hold, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd42));
    for (int i = 0; i < NP; i++) exp_map[i] = 3'(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !sclk && !sload && !sdata, "R1 reset outputs",
        {busy, sclk, sload, sdata}, 0);
    // R1 + R2: bit 21 gives activity, remaining pattern still zero
    frame(3, 32'h0020_0000, 0, 0, 0);
    // R5: poke during frame must be ignored
    frame(0, 32'h0000_0000, 2, 3, 1);
    frame(5, 32'h0048_0000, 1, 0, 0);
    // R4: boundary slot values
    frame(1, 32'h0010_0F00, 0, 0, 0);
    frame(1, 32'h0010_0E00, 0, 1, 0);
    // R3: remap then update
    remap(2, 7);
    frame(2, 32'h0010_0000, 0, 0, 0);
    // R2: clear fields
    frame(3, 32'h0000_0000, 0, 0, 0);
    for (int k = 0; k < 25; k++) begin
      logic [31:0] st;
      if ($urandom % 4 == 0) remap(int'($urandom % NP), int'($urandom % NP));
      st = $urandom;
      st[15:8] = 8'($urandom % 20);
      frame(int'($urandom % NP), st, int'($urandom % 4), int'($urandom % 4), bit'($urandom % 3 == 0));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule